// File: doc/BRIEF.md
# DAC Command Register Controller

This block is the digital control core of a single-channel voltage-output converter that is commanded over a two-wire serial bus. A separate bus slave removes framing and hands over the payload as three bytes, each marked by a one-cycle valid strobe, followed by a word-complete strobe at the acknowledge of the third byte. The block gathers those bytes into a 24-bit word. Bits 23:20 of the word hold a 4-bit command, bits 19:16 are not used, and bits 15:0 hold a left-justified code. The block keeps an input register and a converter register, tracks whether the channel is powered down, and emits a one-cycle pulse each time the converter register is written.

An active-low load pin, asynchronous to the system clock, passes through a synchronizer. When no word is arriving, it copies the input register into the converter register. When it goes low during a transfer, it only wakes the channel. When it is still low as the word completes, the received command runs first and a copy follows. Resolution is set by a parameter to 12, 14 or 16 bits.

The controller is a four-state machine. IDLE waits; it moves to RECV when the first byte of a word arrives, or to LOAD on a falling edge of the synchronized load pin. RECV holds while bytes arrive and moves to EXEC on a completed three-byte word, or back to IDLE if the bytes are abandoned. EXEC applies the command, then moves to LOAD if the load pin was low at completion and to IDLE otherwise. LOAD copies the input register into the converter register and returns to IDLE.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset the converter code is zero, the input register is zero, the channel is powered down (pwr_down = 1) and upd_pulse is low.
- R2: Command 4'b0000 writes the data field into the input register only; the converter code, the power state and upd_pulse do not change.
- R3: Command 4'b0001 copies the input register into the converter register and powers the channel up; every converter update leaves pwr_down at 0.
- R4: Command 4'b0011 writes the data field into the input register and into the converter register, and powers up.
- R5: Command 4'b0100 sets pwr_down and changes neither the input register nor the converter register; its data field is not used.
- R6: Command 4'b1111 and every code other than 0000, 0001, 0011, 0100 and 1111 change no register and leave the power state as it was.
- R7: The code is taken from word bits 15 down to 16-RES. Bits 19:16 and the bits below the code are ignored.
- R8: With no transfer in progress, a falling edge on load_n copies the input register into the converter register and powers up.
- R9: A low on load_n while a word is arriving powers the channel up but does not by itself write the converter register.
- R10: If load_n is low when the word completes, the command executes first and the input register is then copied to the converter register; a power-down command in that word is suppressed.
- R11: upd_pulse is high for exactly one clock for each write of the converter register, and the converter code never changes without it.
- R12: A word-complete strobe that follows fewer than three bytes discards the partial word without effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Deframed payload byte, first byte first |
| rx_byte_vld | input | 1 | One-cycle strobe qualifying rx_byte |
| rx_word_done | input | 1 | Word-complete strobe at the third byte acknowledge |
| load_n | input | 1 | Asynchronous active-low load pin |
| dac_code | output | RES | Converter register contents |
| pwr_down | output | 1 | High while the channel is powered down |
| upd_pulse | output | 1 | One-cycle pulse on each converter register write |

## Verification
The bench targets the interaction between the load pin and a word in flight. A design that updated on a mid-transfer pulse would produce an update the scoreboard never expected. A design that ignored a held pin at completion would miss the trailing copy. A design that let a held pin fail to block power-down would report pwr_down high. Reserved codes and a power-down are each followed by a plain update command. A design that corrupted the input register there would show the wrong code. A short word aimed at an update checks that partial words are dropped. A write-and-update under a held pin must produce two pulses.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    typedef enum logic [3:0] {
        CMD_WR_IN  = 4'b0000,
        CMD_UPD    = 4'b0001,
        CMD_WR_UPD = 4'b0011,
        CMD_PWR_DN = 4'b0100,
        CMD_NOP    = 4'b1111
    } dac_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_EXEC,
        ST_LOAD
    } ctrl_st_e;

    localparam int WORD_BYTES = 3;
    localparam int BYTE_W     = 8;
    localparam int FIELD_W    = 16;

endpackage

// File: rtl/dac_ld_sync.sv
module dac_ld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // resets to the inactive (high) level of the load pin
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/dac_word_asm.sv
module dac_word_asm #(
    parameter int NBYTES = 3,
    parameter int BW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BW-1:0]        byte_in,
    input  logic                 byte_vld,
    input  logic                 word_done,
    output logic                 busy,
    output logic                 done_ok,
    output logic [NBYTES*BW-1:0] word
);
    localparam int WW = NBYTES * BW;
    localparam int CW = $clog2(NBYTES + 1);

    logic [CW-1:0] cnt;
    logic [WW-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (word_done) begin
            cnt <= '0;
        end else if (byte_vld && (cnt != CW'(NBYTES))) begin
            sh  <= {sh[WW-BW-1:0], byte_in};
            cnt <= cnt + 1'b1;
        end
    end

    assign busy    = (cnt != '0);
    assign done_ok = word_done && (cnt == CW'(NBYTES));
    assign word    = sh;
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int RES         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [7:0]     rx_byte,
    input  logic           rx_byte_vld,
    input  logic           rx_word_done,
    input  logic           load_n,
    output logic [RES-1:0] dac_code,
    output logic           pwr_down,
    output logic           upd_pulse
);
    localparam int WW      = WORD_BYTES * BYTE_W;
    localparam int CMD_MSB = WW - 1;
    localparam int CMD_LSB = WW - 4;
    localparam int DAT_MSB = FIELD_W - 1;

    ctrl_st_e state_q, state_d;

    logic          ld_sync, ld_prev, ld_act, ld_fall;
    logic          asm_busy, asm_done;
    logic [WW-1:0] asm_word;

    logic [3:0]     cmd_q;
    logic [RES-1:0] dat_q, inp_q, dac_q;
    logic           ld_flag, pd_q, upd_q;

    dac_ld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (load_n),
        .q     (ld_sync)
    );

    dac_word_asm #(.NBYTES(WORD_BYTES), .BW(BYTE_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_in   (rx_byte),
        .byte_vld  (rx_byte_vld),
        .word_done (rx_word_done),
        .busy      (asm_busy),
        .done_ok   (asm_done),
        .word      (asm_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ld_prev <= 1'b1;
        else        ld_prev <= ld_sync;
    end

    assign ld_act  = !ld_sync;
    assign ld_fall = ld_prev && !ld_sync;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (asm_busy)     state_d = ST_RECV;
                else if (ld_fall) state_d = ST_LOAD;
            end
            ST_RECV: begin
                if (asm_done)       state_d = ST_EXEC;
                else if (!asm_busy) state_d = ST_IDLE;
            end
            ST_EXEC: state_d = ld_flag ? ST_LOAD : ST_IDLE;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NOP;
            dat_q   <= '0;
            inp_q   <= '0;
            dac_q   <= '0;
            ld_flag <= 1'b0;
            pd_q    <= 1'b1;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_RECV: begin
                    if (asm_done) begin
                        cmd_q   <= asm_word[CMD_MSB:CMD_LSB];
                        dat_q   <= asm_word[DAT_MSB -: RES];
                        ld_flag <= ld_act;
                    end
                end
                ST_EXEC: begin
                    case (cmd_q)
                        CMD_WR_IN: inp_q <= dat_q;
                        CMD_UPD: begin
                            dac_q <= inp_q;
                            pd_q  <= 1'b0;
                            upd_q <= 1'b1;
                        end
                        CMD_WR_UPD: begin
                            inp_q <= dat_q;
                            dac_q <= dat_q;
                            pd_q  <= 1'b0;
                            upd_q <= 1'b1;
                        end
                        CMD_PWR_DN: if (!ld_flag) pd_q <= 1'b1;
                        default: ;
                    endcase
                end
                ST_LOAD: begin
                    dac_q <= inp_q;
                    pd_q  <= 1'b0;
                    upd_q <= 1'b1;
                end
                default: ;
            endcase
            // a low load pin wakes the channel whatever the bus is doing
            if (ld_act) pd_q <= 1'b0;
        end
    end

    assign dac_code  = dac_q;
    assign pwr_down  = pd_q;
    assign upd_pulse = upd_q;
endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk
    import dac_ctrl_pkg::*;
#(
    parameter int RES = 16
) (
    input logic           clk,
    input logic           rst_n,
    input ctrl_st_e       state,
    input logic [RES-1:0] dac_code,
    input logic           pwr_down,
    input logic           upd_pulse
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == '0 && pwr_down && !upd_pulse));

    // R11
    a_r11_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> upd_pulse);

    // R3
    a_r3_update_powers_up: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> !pwr_down);

    // R5
    a_r5_pd_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $stable(dac_code));

    // R9
    a_r9_no_update_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV) |-> !upd_pulse);
endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(.RES(RES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .dac_code  (dac_code),
    .pwr_down  (pwr_down),
    .upd_pulse (upd_pulse)
);

// File: tb/test_dac_cmd_ctrl.sv
module test_dac_cmd_ctrl;
    localparam int RES = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     rx_byte = '0;
    logic           rx_byte_vld = 1'b0;
    logic           rx_word_done = 1'b0;
    logic           load_n = 1'b1;
    logic [RES-1:0] dac_code;
    logic           pwr_down;
    logic           upd_pulse;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [RES-1:0] exp_q[$];
    logic [RES-1:0] m_inp = '0;
    logic [RES-1:0] m_dac = '0;
    logic           m_pd = 1'b1;

    always #10 clk = ~clk;

    dac_cmd_ctrl #(.RES(RES)) i_dac_cmd_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_byte      (rx_byte),
        .rx_byte_vld  (rx_byte_vld),
        .rx_word_done (rx_word_done),
        .load_n       (load_n),
        .dac_code     (dac_code),
        .pwr_down     (pwr_down),
        .upd_pulse    (upd_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // monitor: every update pulse pops one expected code
    always @(negedge clk) begin
        if (rst_n && upd_pulse && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected update, code", 32'(dac_code), 32'(m_dac));
            end else begin
                logic [RES-1:0] e;
                e = exp_q.pop_front();
                check(dac_code == e, "R11", "updated code", 32'(dac_code), 32'(e));
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b;
        rx_byte_vld = 1'b1;
        @(negedge clk);
        rx_byte_vld = 1'b0;
        wait_cyc(3);
    endtask

    task automatic end_word();
        @(negedge clk);
        rx_word_done = 1'b1;
        @(negedge clk);
        rx_word_done = 1'b0;
    endtask

    task automatic settle(input string req);
        wait_cyc(8);
        check(exp_q.size() == 0, req, "pending updates", 32'(exp_q.size()), 0);
        check(pwr_down == m_pd, req, "pwr_down", 32'(pwr_down), 32'(m_pd));
        check(dac_code == m_dac, req, "code", 32'(dac_code), 32'(m_dac));
    endtask

    // mode 0: plain, 1: load pulse inside the word, 2: load held through completion
    task automatic send_word(input logic [3:0] cmd, input logic [3:0] pad,
                             input logic [15:0] dat, input int mode, input string req);
        logic [RES-1:0] d;
        bit ld;
        d  = dat[15 -: RES];
        ld = (mode == 2);
        if (mode != 0) m_pd = 1'b0;
        case (cmd)
            4'b0000: m_inp = d;
            4'b0001: begin m_dac = m_inp; exp_q.push_back(m_dac); m_pd = 1'b0; end
            4'b0011: begin m_inp = d; m_dac = d; exp_q.push_back(m_dac); m_pd = 1'b0; end
            4'b0100: if (!ld) m_pd = 1'b1;
            default: ;
        endcase
        if (ld) begin
            m_dac = m_inp;
            exp_q.push_back(m_dac);
            m_pd = 1'b0;
        end
        put_byte({cmd, pad});
        if (mode != 0) load_n = 1'b0;
        put_byte(dat[15:8]);
        if (mode == 1) begin
            wait_cyc(4);
            check(pwr_down == 1'b0, "R9", "wake during transfer", 32'(pwr_down), 0);
            load_n = 1'b1;
        end
        put_byte(dat[7:0]);
        end_word();
        wait_cyc(6);
        if (mode == 2) load_n = 1'b1;
        settle(req);
    endtask

    task automatic idle_load(input string req);
        m_dac = m_inp;
        m_pd  = 1'b0;
        exp_q.push_back(m_dac);
        @(negedge clk);
        load_n = 1'b0;
        wait_cyc(8);
        load_n = 1'b1;
        settle(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        // R1
        check(dac_code == '0, "R1", "reset code", 32'(dac_code), 0);
        check(pwr_down == 1'b1, "R1", "reset pwr_down", 32'(pwr_down), 1);
        check(upd_pulse == 1'b0, "R1", "reset pulse", 32'(upd_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(3);
        check(dac_code == '0 && pwr_down, "R1", "after release", 32'(dac_code), 0);

        send_word(4'b0000, 4'h0, 16'hA5A5, 0, "R2");     // R2 input only
        send_word(4'b0001, 4'h0, 16'h0000, 0, "R3");     // R3 copy and wake
        send_word(4'b0011, 4'hF, 16'h1234, 0, "R4");     // R4, R7 pad bits ignored
        send_word(4'b0100, 4'h0, 16'hFFFF, 0, "R5");     // R5 power down
        send_word(4'b0001, 4'h0, 16'hBEEF, 0, "R5");     // R5 input kept through PD
        send_word(4'b0100, 4'h0, 16'h0000, 0, "R5");
        send_word(4'b0010, 4'h0, 16'h4321, 0, "R6");     // R6 reserved codes
        send_word(4'b0101, 4'h3, 16'h1111, 0, "R6");
        send_word(4'b1000, 4'h0, 16'h2222, 0, "R6");
        send_word(4'b1110, 4'h0, 16'h3333, 0, "R6");
        send_word(4'b1111, 4'h0, 16'h4444, 0, "R6");     // R6 no-op
        send_word(4'b0001, 4'h0, 16'h0000, 0, "R6");     // input still 1234
        send_word(4'b0011, 4'hA, 16'hC3C3, 0, "R7");     // R7 code taken from 15:0
        send_word(4'b0100, 4'h0, 16'h0000, 0, "R8");
        send_word(4'b0000, 4'h0, 16'h7777, 0, "R8");
        idle_load("R8");                                  // R8 idle load edge
        send_word(4'b0100, 4'h0, 16'h0000, 0, "R9");
        send_word(4'b0000, 4'h0, 16'h8888, 1, "R9");     // R9 wake without update
        send_word(4'b0100, 4'h0, 16'h0000, 2, "R10");    // R10 PD suppressed, copy
        send_word(4'b0000, 4'h0, 16'h9999, 2, "R10");    // R10 write then copy
        send_word(4'b0011, 4'h0, 16'h5A5A, 2, "R11");    // R11 two pulses

        // R12: short word aimed at an update is dropped
        send_word(4'b0000, 4'h0, 16'h6666, 0, "R12");
        put_byte({4'b0011, 4'h0});
        put_byte(8'h11);
        end_word();
        settle("R12");
        send_word(4'b0001, 4'h0, 16'h0000, 0, "R12");    // input still 6666

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule